// File: doc/BRIEF.md
# Chirp Frame Nibble Assembler

This block turns one radio frame's configuration and payload into the ordered stream of 4-bit data words that the channel encoder consumes. A one-cycle `start` pulse captures the frame settings: payload byte count, coding-rate field, checksum-present flag, spreading factor and a precomputed 16-bit payload checksum. The block then emits five explicit-header nibbles, the payload nibbles, the checksum nibbles when enabled, and finally zero nibbles. The zero nibbles make the frame fill whole interleaver groups.

Payload bytes arrive on a valid/ready byte stream and are consumed only when the block needs them. Each payload byte is XORed with the current state of an 8-bit whitening shift register before it is split into nibbles. The header and the checksum are never whitened. Nibbles leave through a registered valid/ready stream, and a last flag marks the final nibble of the frame. The 8-bit header checksum is a GF(2)-linear function of the first twelve header bits. A 5x12 bit matrix parameter defines its five low bits, and its three high bits are always zero.

Top module: `fna_frame_nibbler`

## Requirements
- R1: The first three nibbles of a frame are len[7:4], then len[3:0], then a nibble whose bits 3..1 hold the 3-bit coding-rate field and whose bit 0 holds the checksum-present flag.
- R2: With H = {len[7:0], cr[2:0], crc_en} (bit 11 = len[7]), checksum bit i (i = 0..4) is the XOR of (HDR_CHK_MATRIX[12i+11:12i] & H). Nibble 3 is {3'b000, c[4]} and nibble 4 is c[3:0].
- R3: Payload byte k (k = 0..len-1) is emitted as two nibbles, high nibble first, after XOR with whitening byte w_k.
- R4: w_0 = 8'hFF and w_{k+1} = {w_k[6:0], w_k[7]^w_k[5]^w_k[4]^w_k[3]}. The sequence restarts at every frame and does not depend on the spreading factor or the coding-rate field.
- R5: When crc_en is 1, four unwhitened nibbles follow the payload: chk[15:12], chk[11:8], chk[7:4], chk[3:0]. When crc_en is 0, none are emitted.
- R6: With N = 2*len + 4*crc_en data nibbles and A = sf - 7, the block appends P zero nibbles. P = A - N when N <= A. Otherwise P = (sf - ((N - A) mod sf)) mod sf.
- R7: out_last is 1 on exactly one transferred nibble per frame: the final one, counting from the header through the padding.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_nib and out_last hold their values.
- R9: in_ready is 1 only while the block waits for the next payload byte. Exactly len bytes are taken per frame, and a gap on in_valid stalls the stream without changing its content.
- R10: Configuration is sampled on an accepted start in the idle state. A start pulse or configuration change during a frame has no effect on that frame.
- R11: After reset, out_valid, out_last and in_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| cfg_len | input | 8 | Payload byte count |
| cfg_cr | input | 3 | Coding-rate field placed in the header |
| cfg_crc_en | input | 1 | Payload checksum present |
| cfg_sf | input | 4 | Spreading factor, 7 to 12 |
| cfg_chk | input | 16 | Precomputed payload checksum |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| out_valid | output | 1 | Nibble valid |
| out_nib | output | 4 | Output nibble |
| out_last | output | 1 | Final nibble of the frame |
| out_ready | input | 1 | Consumer takes the nibble |

## Verification
The hardest situations to reach are frames whose data are wholly absorbed into the header group, which need padding even for short or empty payloads at large spreading factors. Alongside those, a starved byte input can coincide with a stalled consumer at the moment the block switches from the high nibble to the low nibble. The bench sweeps every length from 0 to 20 at each spreading factor from 7 to 12, with and without the checksum. Every other frame uses interleaved gap patterns on in_valid and out_ready. Some frames raise start with altered settings mid-frame. Full-length frames then check the whitening sequence far into its period.

// File: rtl/fna_pkg.sv
package fna_pkg;
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int HDR_NIBS   = 5;
  localparam int HDR_BITS   = 12;
  localparam int CHK_BITS   = 5;
  localparam int CHK_NIBS   = 4;
  localparam logic [BYTE_W-1:0] WHT_SEED = 8'hFF;
  localparam logic [BYTE_W-1:0] WHT_TAPS = 8'b1011_1000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_PAY,
    PH_CHK,
    PH_PAD
  } phase_t;

  function automatic logic [BYTE_W-1:0] wht_step(input logic [BYTE_W-1:0] s);
    return {s[BYTE_W-2:0], ^(s & WHT_TAPS)};
  endfunction
endpackage

// File: rtl/fna_hdr_gen.sv
module fna_hdr_gen
  import fna_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CR_W  = 3,
  parameter logic [CHK_BITS*HDR_BITS-1:0] HDR_CHK_MATRIX = 60'hF0F_CC3_AA5_39C_E61
) (
  input  logic [LEN_W-1:0]          len,
  input  logic [CR_W-1:0]           cr,
  input  logic                      crc_en,
  output logic [HDR_NIBS*NIB_W-1:0] nibs
);
  logic [HDR_BITS-1:0] hbits;
  logic [CHK_BITS-1:0] csum;

  assign hbits = {len, cr, crc_en};

  for (genvar gi = 0; gi < CHK_BITS; gi++) begin : g_csum
    assign csum[gi] = ^(HDR_CHK_MATRIX[gi*HDR_BITS +: HDR_BITS] & hbits);
  end

  always_comb begin
    nibs = '0;
    nibs[0*NIB_W +: NIB_W] = len[LEN_W-1 -: NIB_W];
    nibs[1*NIB_W +: NIB_W] = len[NIB_W-1:0];
    nibs[2*NIB_W +: NIB_W] = {cr, crc_en};
    nibs[3*NIB_W +: NIB_W] = {3'b000, csum[CHK_BITS-1]};
    nibs[4*NIB_W +: NIB_W] = csum[NIB_W-1:0];
  end
endmodule

// File: rtl/fna_whitener.sv
module fna_whitener
  import fna_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  output logic [BYTE_W-1:0] mask
);
  logic [BYTE_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst || restart) state <= WHT_SEED;
    else if (advance)   state <= wht_step(state);
  end

  assign mask = state;

  AST_WHT_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R4
endmodule

// File: rtl/fna_pad_calc.sv
module fna_pad_calc
  import fna_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int SF_W    = 4,
  parameter int BASE_SF = 7,
  parameter int TOT_W   = LEN_W + 3
) (
  input  logic [LEN_W-1:0] len,
  input  logic             crc_en,
  input  logic [SF_W-1:0]  sf,
  output logic [TOT_W-1:0] total
);
  logic [TOT_W-1:0] sf_w, absorb, n_data, over, rem, pad;

  always_comb begin
    sf_w   = TOT_W'(sf);
    absorb = sf_w - TOT_W'(BASE_SF);
    n_data = TOT_W'({len, 1'b0}) + (crc_en ? TOT_W'(CHK_NIBS) : '0);
    over   = n_data - absorb;
    rem    = (sf_w != '0) ? (over % sf_w) : '0;
    if (n_data <= absorb) pad = absorb - n_data;
    else if (rem == '0)   pad = '0;
    else                  pad = sf_w - rem;
    total = TOT_W'(HDR_NIBS) + n_data + pad;
  end
endmodule

// File: rtl/fna_frame_nibbler.sv
module fna_frame_nibbler
  import fna_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int CR_W    = 3,
  parameter int SF_W    = 4,
  parameter int CHK_W   = 16,
  parameter int BASE_SF = 7,
  parameter logic [CHK_BITS*HDR_BITS-1:0] HDR_CHK_MATRIX = 60'hF0F_CC3_AA5_39C_E61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [CR_W-1:0]   cfg_cr,
  input  logic              cfg_crc_en,
  input  logic [SF_W-1:0]   cfg_sf,
  input  logic [CHK_W-1:0]  cfg_chk,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [NIB_W-1:0]  out_nib,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int TOT_W = LEN_W + 3;
  localparam int IDX_W = 3;

  phase_t               phase;
  logic [LEN_W-1:0]     len_q;
  logic [CR_W-1:0]      cr_q;
  logic                 crc_q;
  logic [CHK_W-1:0]     chk_q;
  logic [TOT_W-1:0]     total_q, total_c, cnt;
  logic [IDX_W-1:0]     idx;
  logic                 half;
  logic [LEN_W-1:0]     byte_cnt;
  logic [NIB_W-1:0]     hold_nib;
  logic [HDR_NIBS*NIB_W-1:0] hdr_flat;
  logic [BYTE_W-1:0]    mask;
  logic                 can_load, ld, start_acc, byte_acc, is_last;
  logic [NIB_W-1:0]     nxt_nib;
  phase_t               after_hdr, after_pay;

  fna_hdr_gen #(.LEN_W(LEN_W), .CR_W(CR_W), .HDR_CHK_MATRIX(HDR_CHK_MATRIX)) hdr_i (
    .len(len_q), .cr(cr_q), .crc_en(crc_q), .nibs(hdr_flat));

  fna_pad_calc #(.LEN_W(LEN_W), .SF_W(SF_W), .BASE_SF(BASE_SF), .TOT_W(TOT_W)) pad_i (
    .len(cfg_len), .crc_en(cfg_crc_en), .sf(cfg_sf), .total(total_c));

  fna_whitener wht_i (
    .clk(clk), .rst(rst), .restart(start_acc), .advance(byte_acc), .mask(mask));

  assign start_acc = start && (phase == PH_IDLE);
  assign can_load  = !out_valid || out_ready;
  assign in_ready  = (phase == PH_PAY) && !half && can_load;
  assign byte_acc  = in_valid && in_ready;
  assign ld        = can_load &&
                     ((phase == PH_HDR) || (phase == PH_CHK) || (phase == PH_PAD) ||
                      ((phase == PH_PAY) && (half || in_valid)));
  assign is_last   = (cnt == total_q - TOT_W'(1));
  assign after_hdr = (len_q != '0) ? PH_PAY : (crc_q ? PH_CHK : PH_PAD);
  assign after_pay = crc_q ? PH_CHK : PH_PAD;

  always_comb begin
    nxt_nib = '0;
    case (phase)
      PH_HDR:  nxt_nib = hdr_flat[{idx, 2'b00} +: NIB_W];
      PH_PAY:  nxt_nib = half ? hold_nib : (in_data[BYTE_W-1 -: NIB_W] ^ mask[BYTE_W-1 -: NIB_W]);
      PH_CHK:  nxt_nib = chk_q[{~idx[1:0], 2'b00} +: NIB_W];
      default: nxt_nib = '0;
    endcase
  end

  // frame sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      len_q    <= '0;
      cr_q     <= '0;
      crc_q    <= 1'b0;
      chk_q    <= '0;
      total_q  <= '0;
      cnt      <= '0;
      idx      <= '0;
      half     <= 1'b0;
      byte_cnt <= '0;
      hold_nib <= '0;
    end else if (start_acc) begin
      phase    <= PH_HDR;
      len_q    <= cfg_len;
      cr_q     <= cfg_cr;
      crc_q    <= cfg_crc_en;
      chk_q    <= cfg_chk;
      total_q  <= total_c;
      cnt      <= '0;
      idx      <= '0;
      half     <= 1'b0;
      byte_cnt <= '0;
    end else if (ld) begin
      cnt <= cnt + TOT_W'(1);
      case (phase)
        PH_HDR: begin
          if (idx == IDX_W'(HDR_NIBS - 1)) begin
            idx   <= '0;
            phase <= after_hdr;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        PH_PAY: begin
          if (!half) begin
            half     <= 1'b1;
            hold_nib <= in_data[NIB_W-1:0] ^ mask[NIB_W-1:0];
          end else begin
            half     <= 1'b0;
            byte_cnt <= byte_cnt + LEN_W'(1);
            if (byte_cnt == len_q - LEN_W'(1)) phase <= after_pay;
          end
        end
        PH_CHK: begin
          if (idx == IDX_W'(CHK_NIBS - 1)) begin
            idx   <= '0;
            phase <= PH_PAD;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: ;
      endcase
      if (is_last) phase <= PH_IDLE;
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_nib   <= '0;
      out_last  <= 1'b0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_nib   <= nxt_nib;
      out_last  <= is_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R7
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_nib) && $stable(out_last)); // R8
  AST_BYTE_YIELDS_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R3
  AST_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ld && phase == PH_PAD |=> out_nib == '0); // R6
  AST_CHK_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ld && phase == PH_HDR && idx == IDX_W'(3) |=> out_nib[NIB_W-1:1] == '0); // R2
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    start && phase != PH_IDLE |=> $stable(len_q) && $stable(total_q) && $stable(chk_q)); // R10
endmodule

// File: tb/fna_frame_nibbler_tb_top.sv
module fna_frame_nibbler_tb_top;
  localparam logic [59:0] MTX = 60'h5A3_C96_0FF_B41_7E2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] cfg_len = '0;
  logic [2:0] cfg_cr = '0;
  logic cfg_crc_en = 1'b0;
  logic [3:0] cfg_sf = 4'd7;
  logic [15:0] cfg_chk = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [3:0] out_nib;
  logic out_ready = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] exp_nib [0:1023];
  int exp_n;
  logic [7:0] pay [0:255];

  always #5 clk = ~clk;

  fna_frame_nibbler #(.HDR_CHK_MATRIX(MTX)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_cr(cfg_cr),
    .cfg_crc_en(cfg_crc_en), .cfg_sf(cfg_sf), .cfg_chk(cfg_chk),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_nib(out_nib), .out_last(out_last), .out_ready(out_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_expected(input int len, input int cr, input int crc, input int sf,
                                input logic [15:0] chk);
    logic [11:0] h;
    logic [4:0] c;
    logic [7:0] w;
    int n, a, p, r;
    h = {8'(len), 3'(cr), 1'(crc)};
    for (int i = 0; i < 5; i++) c[i] = ^(MTX[12*i +: 12] & h);
    exp_n = 0;
    exp_nib[exp_n++] = h[11:8];
    exp_nib[exp_n++] = h[7:4];
    exp_nib[exp_n++] = h[3:0];
    exp_nib[exp_n++] = {3'b000, c[4]};
    exp_nib[exp_n++] = c[3:0];
    w = 8'hFF;
    for (int k = 0; k < len; k++) begin
      exp_nib[exp_n++] = pay[k][7:4] ^ w[7:4];
      exp_nib[exp_n++] = pay[k][3:0] ^ w[3:0];
      w = {w[6:0], w[7] ^ w[5] ^ w[4] ^ w[3]};
    end
    if (crc != 0) begin
      exp_nib[exp_n++] = chk[15:12];
      exp_nib[exp_n++] = chk[11:8];
      exp_nib[exp_n++] = chk[7:4];
      exp_nib[exp_n++] = chk[3:0];
    end
    n = 2 * len + 4 * crc;
    a = sf - 7;
    if (n <= a) p = a - n;
    else begin
      r = (n - a) % sf;
      p = (r == 0) ? 0 : sf - r;
    end
    for (int i = 0; i < p; i++) exp_nib[exp_n++] = 4'h0;
  endtask

  function automatic string tag_of(input int i, input int len, input int crc);
    if (i < 3) return "R1";
    if (i < 5) return "R2";
    if (i < 5 + 2 * len) return "R3/R4";
    if (crc != 0 && i < 9 + 2 * len) return "R5";
    return "R6";
  endfunction

  task automatic run_frame(input int len, input int cr, input int crc, input int sf,
                           input logic [15:0] chk, input int seed, input bit stall,
                           input bit poke);
    int nidx, bidx, cyc;
    bit done, bad_ready, was_stalled;
    logic [3:0] prev_nib;
    for (int k = 0; k < 256; k++) pay[k] = 8'((k * 37 + seed * 11 + 5) & 255);
    build_expected(len, cr, crc, sf, chk);
    @(negedge clk);
    cfg_len = 8'(len); cfg_cr = 3'(cr); cfg_crc_en = 1'(crc);
    cfg_sf = 4'(sf); cfg_chk = chk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nidx = 0; bidx = 0; cyc = 0; done = 0; bad_ready = 0; was_stalled = 0; prev_nib = '0;
    while (!done) begin
      out_ready = stall ? (((cyc + seed) % 3) != 0) : 1'b1;
      in_valid  = stall ? (((cyc + seed) % 4) != 1) : 1'b1;
      in_data   = (bidx < 256) ? pay[bidx] : 8'h00;
      if (poke && cyc == 7) begin
        start = 1'b1;
        cfg_len = ~cfg_len; cfg_crc_en = ~cfg_crc_en; cfg_chk = ~cfg_chk; cfg_sf = 4'd12;
      end else start = 1'b0;
      #1;
      if (was_stalled)
        check(out_valid && out_nib == prev_nib, "R8 hold", int'(out_nib), int'(prev_nib));
      was_stalled = out_valid && !out_ready;
      prev_nib = out_nib;
      if (in_ready && bidx >= len) bad_ready = 1;
      if (out_valid && out_ready) begin
        if (nidx < exp_n)
          check(out_nib == exp_nib[nidx], poke ? "R10" : tag_of(nidx, len, crc),
                int'(out_nib), int'(exp_nib[nidx]));
        check(out_last == (nidx == exp_n - 1), "R7 last", int'(out_last),
              int'(nidx == exp_n - 1));
        if (out_last) done = 1;
        nidx++;
      end
      if (in_valid && in_ready) bidx++;
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "watchdog", cyc, 5000);
        done = 1;
      end
    end
    start = 1'b0;
    check(nidx == exp_n, "R6 count", nidx, exp_n);
    check(!bad_ready && bidx == len, "R9 bytes", bidx, len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !out_last && !in_ready, "R11 in reset",
          int'({out_valid, out_last, in_ready}), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && !in_ready, "R11 after reset", int'({out_valid, in_ready}), 0);
    for (int sf = 7; sf <= 12; sf++)
      for (int crc = 0; crc < 2; crc++)
        for (int len = 0; len <= 20; len++)
          run_frame(len, (len + sf) % 8, crc, sf, 16'(16'hA5C3 ^ (len << 4) ^ sf),
                    len + 3 * sf + crc, bit'(len % 2), (len == 5 || len == 13));
    run_frame(255, 5, 1, 7, 16'h1D0F, 91, 1'b1, 1'b0);
    run_frame(255, 2, 0, 12, 16'h0000, 17, 1'b0, 1'b1);
    run_frame(128, 7, 1, 9, 16'hBEEF, 44, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule